// File: doc/BRIEF.md
# Timekeeper register window decoder

This block sits between a host byte bus and an external static RAM. It lays sixteen timekeeping register bytes over the top sixteen addresses of a 19-bit byte address space. Every other address goes straight to the RAM. The block drives the RAM chip enable and output enable. Whenever the host address falls inside the register window, the RAM output enable is held off and the read data comes from the register byte instead. The host therefore sees one continuous memory map, from address zero up to the last register.

Eight of the sixteen bytes hold the time. A clock source outside this block refreshes them once per second from a snapshot bus. The control byte can stop these refreshes so that the host reads a stable, coherent time. The calendar, the alarm match, the watchdog, supply sensing and battery switchover all live outside this block. The register bytes here only store their settings and status.

Top module: `tk_window_decoder`

## Requirements
- R1: Addresses 0x7FFF0 to 0x7FFFF form the register window, and window offset = address bits [3:0]. A host read in the window returns, on `host_rdata`, the register byte at that offset, in the same cycle.
- R2: For addresses below 0x7FFF0, `host_rdata` equals `ram_rdata` and `ram_oe_n` equals `host_oe_n` (when write protect is low).
- R3: While the address lies in the window, `ram_oe_n` is 1 whatever `host_oe_n` is.
- R4: With write protect low, `ram_ce_n` equals `host_ce_n` for every address.
- R5: A host write (`host_ce_n`=0, `host_we_n`=0, address in the window, write protect low) stores `host_wdata` in the addressed byte at that clock edge. A read in the next cycle returns it.
- R6: On a clock edge with `tick_1hz`=1 and refresh not frozen, snapshot byte i (`snap_time[8i+7:8i]`) loads offset 9+i for i=0..6, and snapshot byte 7 loads offset 1. The other offsets keep their values.
- R7: While bit 7 or bit 6 of the control byte (offset 8) is set, a tick loads nothing. Once both bits are clear, the next tick loads the snapshot.
- R8: When a host write and a snapshot load hit the same byte at one edge, the byte takes the host data.
- R9: With `wprot`=1, `ram_ce_n` and `ram_oe_n` are both 1 and host writes to the window change no byte.
- R10: A synchronous active-low reset clears all sixteen register bytes to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 19 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_rdata | output | 8 | Read data to the host (register byte or RAM byte) |
| wprot | input | 1 | Write protect: blocks RAM enables and register writes |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| snap_time | input | 64 | Time snapshot, eight bytes |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_rdata | input | 8 | Read data from the RAM |

## Verification
A wrong stored byte has no side effect of its own. It shows up only when the host reads that offset, and then it appears on `host_rdata` in the same cycle as the read. For that reason the bench keeps a byte-exact model of all sixteen registers and compares every window read against it. A wrong freeze decode or a wrong write-versus-load priority becomes visible on the first read after the edge where the refresh or the collision happened. The enable outputs are combinational, so a wrong window decode shows up on `ram_oe_n` in the very cycle the address is presented.

// File: rtl/tk_pkg.sv
// Shared constants and helpers for the timekeeper register window.
// Assumes an 8-bit data bus and a 16-byte window at the top of the map.
package tk_pkg;
    localparam int ADDR_W    = 19;
    localparam int DATA_W    = 8;
    localparam int OFF_W     = 4;
    localparam int NREG      = 1 << OFF_W;
    localparam int NSNAP     = 8;
    localparam int CTRL_OFF  = 8;
    localparam int FRZ_WR    = 7;
    localparam int FRZ_RD    = 6;
    localparam int TIME_BASE = 9;
    localparam int CENT_OFF  = 1;

    // Snapshot byte index that feeds a given register offset, or -1 for none.
    function automatic int snap_index(input int off);
        if (off >= TIME_BASE && off < TIME_BASE + NSNAP - 1)
            return off - TIME_BASE;
        else if (off == CENT_OFF)
            return NSNAP - 1;
        else
            return -1;
    endfunction
endpackage

// File: rtl/tk_addr_decode.sv
// Address window decode and RAM enable generation.
// Assumes the window occupies the top 2**OFF_W byte addresses.
module tk_addr_decode #(
    parameter int ADDR_W = tk_pkg::ADDR_W,
    parameter int OFF_W  = tk_pkg::OFF_W
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_ce_n,
    input  logic              host_oe_n,
    input  logic              wprot,
    output logic              win_hit,
    output logic [OFF_W-1:0]  win_off,
    output logic              ram_ce_n,
    output logic              ram_oe_n
);
    // Window hit when every upper address bit is one; RAM enables gated by protect and hit.
    always_comb begin
        win_hit  = &host_addr[ADDR_W-1:OFF_W];
        win_off  = host_addr[OFF_W-1:0];
        ram_ce_n = host_ce_n | wprot;
        ram_oe_n = host_oe_n | wprot | win_hit;
    end
endmodule

// File: rtl/tk_snap_ctrl.sv
// Decides whether a one-second tick may load the snapshot.
// Assumes the freeze bits are read from the stored control byte.
module tk_snap_ctrl #(
    parameter int DATA_W = tk_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic              tick,
    output logic              frozen,
    output logic              snap_load
);
    // Either freeze bit suppresses the load.
    always_comb begin
        frozen    = ctrl_q[tk_pkg::FRZ_WR] | ctrl_q[tk_pkg::FRZ_RD];
        snap_load = tick & ~frozen;
    end
endmodule

// File: rtl/tk_reg_file.sv
// Sixteen register bytes with a host write port and a snapshot load port.
// Assumes the host write takes priority over the snapshot on the same byte.
module tk_reg_file #(
    parameter int DATA_W = tk_pkg::DATA_W,
    parameter int OFF_W  = tk_pkg::OFF_W,
    parameter int NSNAP  = tk_pkg::NSNAP
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [OFF_W-1:0]        wr_off,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    load,
    input  logic [NSNAP*DATA_W-1:0] snap,
    input  logic [OFF_W-1:0]        rd_off,
    output logic [DATA_W-1:0]       rd_data,
    output logic [DATA_W-1:0]       ctrl_q
);
    localparam int NREG = 1 << OFF_W;

    logic [NREG-1:0][DATA_W-1:0] regs;

    for (genvar g = 0; g < NREG; g++) begin : g_byte
        localparam int SIDX = tk_pkg::snap_index(g);
        logic [DATA_W-1:0] q;
        if (SIDX >= 0) begin : g_time
            // Clock byte: host write first, else snapshot load.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_off == OFF_W'(g))
                    q <= wr_data;
                else if (load)
                    q <= snap[SIDX*DATA_W +: DATA_W];
            end
        end else begin : g_plain
            // Setting byte: host write only.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_off == OFF_W'(g))
                    q <= wr_data;
            end
        end
        assign regs[g] = q;
    end

    // Read mux and control byte tap.
    always_comb begin
        rd_data = regs[rd_off];
        ctrl_q  = regs[tk_pkg::CTRL_OFF];
    end

    // R6: an unobstructed load places snapshot byte 0 in offset 9.
    p_load_sec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load && !wr_en |=> regs[tk_pkg::TIME_BASE] == $past(snap[DATA_W-1:0]));
    // R8: host data wins a same-edge collision with the snapshot.
    p_host_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && load |=> regs[$past(wr_off)] == $past(wr_data));
    // R7: no write and no load leaves every byte unchanged.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !load |=> $stable(regs));
endmodule

// File: rtl/tk_window_decoder.sv
// Top: overlays the register window on the RAM map and returns register
// data for window reads. Assumes tick_1hz is a single-cycle pulse.
module tk_window_decoder #(
    parameter int ADDR_W = tk_pkg::ADDR_W,
    parameter int DATA_W = tk_pkg::DATA_W,
    parameter int OFF_W  = tk_pkg::OFF_W,
    parameter int NSNAP  = tk_pkg::NSNAP
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [DATA_W-1:0]       host_wdata,
    input  logic                    host_ce_n,
    input  logic                    host_oe_n,
    input  logic                    host_we_n,
    output logic [DATA_W-1:0]       host_rdata,
    input  logic                    wprot,
    input  logic                    tick_1hz,
    input  logic [NSNAP*DATA_W-1:0] snap_time,
    output logic                    ram_ce_n,
    output logic                    ram_oe_n,
    input  logic [DATA_W-1:0]       ram_rdata
);
    logic              win_hit;
    logic [OFF_W-1:0]  win_off;
    logic              wr_en;
    logic              frozen;
    logic              snap_load;
    logic [DATA_W-1:0] reg_rdata;
    logic [DATA_W-1:0] ctrl_q;

    tk_addr_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
        .host_addr (host_addr),
        .host_ce_n (host_ce_n),
        .host_oe_n (host_oe_n),
        .wprot     (wprot),
        .win_hit   (win_hit),
        .win_off   (win_off),
        .ram_ce_n  (ram_ce_n),
        .ram_oe_n  (ram_oe_n)
    );

    tk_snap_ctrl #(.DATA_W(DATA_W)) u_snap (
        .ctrl_q    (ctrl_q),
        .tick      (tick_1hz),
        .frozen    (frozen),
        .snap_load (snap_load)
    );

    tk_reg_file #(.DATA_W(DATA_W), .OFF_W(OFF_W), .NSNAP(NSNAP)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_off  (win_off),
        .wr_data (host_wdata),
        .load    (snap_load),
        .snap    (snap_time),
        .rd_off  (win_off),
        .rd_data (reg_rdata),
        .ctrl_q  (ctrl_q)
    );

    // Qualified host write into the window, and read data steering.
    always_comb begin
        wr_en      = ~host_ce_n & ~host_we_n & win_hit & ~wprot;
        host_rdata = win_hit ? reg_rdata : ram_rdata;
    end

    // R3: window addresses never enable the RAM outputs.
    p_oe_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&host_addr[ADDR_W-1:OFF_W]) |-> ram_oe_n);
    // R4: chip enable tracks the host when unprotected.
    p_ce_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wprot |-> ram_ce_n == host_ce_n);
    // R9: protect forces both RAM enables off.
    p_wprot_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wprot |-> ram_ce_n && ram_oe_n);
    // R7: a set freeze bit never lets a load through.
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[tk_pkg::FRZ_WR] || ctrl_q[tk_pkg::FRZ_RD]) |-> !snap_load);
    // R2: RAM data passes through below the window.
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> host_rdata == ram_rdata);
endmodule

// File: tb/sim_tk_window_decoder.sv
module sim_tk_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ce_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
    logic [7:0]  host_rdata;
    logic        wprot = 1'b0, tick_1hz = 1'b0;
    logic [63:0] snap_time = '0;
    logic        ram_ce_n, ram_oe_n;
    logic [7:0]  ram_rdata = '0;

    int total = 0, bad = 0;
    logic [7:0] m [16];
    logic [7:0] got;

    always #5 clk = ~clk;

    tk_window_decoder u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .host_rdata(host_rdata), .wprot(wprot), .tick_1hz(tick_1hz),
        .snap_time(snap_time), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
        .ram_rdata(ram_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int snap_of(input int off);
        if (off >= 9) return off - 9;
        if (off == 1) return 7;
        return -1;
    endfunction

    // One bus cycle: drive, check combinational outputs, advance the model.
    task automatic cyc(input logic [18:0] a, input logic ce, input logic oe,
                       input logic we, input logic [7:0] wd, input logic wp,
                       input logic tk, input logic [63:0] sn, input logic [7:0] rr,
                       output logic [7:0] rd);
        logic win;
        logic [3:0] off;
        @(negedge clk);
        host_addr = a; host_ce_n = ce; host_oe_n = oe; host_we_n = we;
        host_wdata = wd; wprot = wp; tick_1hz = tk; snap_time = sn; ram_rdata = rr;
        #1;
        win = &a[18:4];
        off = a[3:0];
        rd = host_rdata;
        chk(wp ? "R9 ram_ce_n" : "R4 ram_ce_n", {7'd0, ram_ce_n}, {7'd0, ce | wp});
        chk(wp ? "R9 ram_oe_n" : (win ? "R3 ram_oe_n" : "R2 ram_oe_n"),
            {7'd0, ram_oe_n}, {7'd0, oe | wp | win});
        chk(win ? "R1 rdata" : "R2 rdata", host_rdata, win ? m[off] : rr);
        if (tk && !(m[8][7] | m[8][6]))
            for (int i = 0; i < 16; i++)
                if (snap_of(i) >= 0) m[i] = sn[snap_of(i)*8 +: 8];
        if (!ce && !we && win && !wp) m[off] = wd;
        @(posedge clk);
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d, input logic wp,
                      input logic tk, input logic [63:0] sn);
        logic [7:0] r;
        cyc({15'h7FFF, off}, 1'b0, 1'b1, 1'b0, d, wp, tk, sn, 8'h00, r);
    endtask

    task automatic rd(input logic [3:0] off, output logic [7:0] r);
        cyc({15'h7FFF, off}, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 64'd0, 8'hEE, r);
    endtask

    task automatic idle_tick(input logic [63:0] sn);
        logic [7:0] r;
        cyc(19'h00100, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, sn, 8'h00, r);
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) m[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10: all bytes zero after reset
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), got); chk("R10 reset byte", got, 8'h00);
        end

        // R5: write then read back
        wr(4'h3, 8'h5A, 1'b0, 1'b0, 64'd0);
        rd(4'h3, got); chk("R5 write readback", got, 8'h5A);

        // R6: snapshot mapping
        idle_tick(64'hC1_77_66_55_44_33_22_11);
        rd(4'h9, got); chk("R6 offset 9", got, 8'h11);
        rd(4'hF, got); chk("R6 offset F", got, 8'h77);
        rd(4'h1, got); chk("R6 century", got, 8'hC1);
        rd(4'h3, got); chk("R6 other kept", got, 8'h5A);

        // R7: freeze by bit 7, then bit 6, then release
        wr(4'h8, 8'h80, 1'b0, 1'b0, 64'd0);
        idle_tick(64'hFF_FF_FF_FF_FF_FF_FF_AA);
        rd(4'h9, got); chk("R7 frozen bit7", got, 8'h11);
        wr(4'h8, 8'h40, 1'b0, 1'b0, 64'd0);
        idle_tick(64'hFF_FF_FF_FF_FF_FF_FF_BB);
        rd(4'h9, got); chk("R7 frozen bit6", got, 8'h11);
        wr(4'h8, 8'h00, 1'b0, 1'b0, 64'd0);
        rd(4'h9, got); chk("R7 no load without tick", got, 8'h11);
        idle_tick(64'h00_00_00_00_00_00_00_CC);
        rd(4'h9, got); chk("R7 load after release", got, 8'hCC);

        // R8: collision on offset A
        wr(4'hA, 8'h3C, 1'b0, 1'b1, 64'h00_00_00_00_00_00_99_88);
        rd(4'hA, got); chk("R8 host wins", got, 8'h3C);
        rd(4'h9, got); chk("R8 neighbour loaded", got, 8'h88);

        // R9: protected write ignored
        wr(4'h4, 8'hA5, 1'b1, 1'b0, 64'd0);
        rd(4'h4, got); chk("R9 write blocked", got, 8'h00);

        // Random traffic, half in the window
        for (int n = 0; n < 4000; n++) begin
            logic [18:0] a;
            logic [7:0] r;
            a = 19'($urandom);
            if ($urandom_range(1, 0) == 1) a[18:4] = 15'h7FFF;
            cyc(a, 1'($urandom_range(3, 0) == 0), 1'($urandom),
                1'($urandom_range(1, 0) == 0), 8'($urandom),
                1'($urandom_range(7, 0) == 0), 1'($urandom_range(3, 0) == 0),
                {$urandom, $urandom}, 8'($urandom), r);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule